// File: doc/BRIEF.md
# Shared-Timebase Edge-Placed PWM Channel

This block is one PWM output channel that owns no counter of its own. It watches the count of a timebase shared with other channels, which counts up from 0 to `tbPeriod - 1` and then restarts. It raises the output when the count reaches a programmable phase-shift position. It drops the output again after a programmable number of duty ticks, and that trailing edge wraps past the end of the period when needed. The output period is therefore always the timebase period, and several channels on one timebase can be set to staggered phases.

Software writes phase, duty and polarity through a small write port into holding registers. The values move into the working compare registers only in the cycle where the timebase raises its boundary strobe, which is high in the cycle its count is 0. The new settings already govern that boundary cycle. A write made in the boundary cycle itself waits for the following boundary. The pin is registered, so its level reflects the count seen one clock earlier.

Top module: `spwm_channel`

## Requirements
- R1: After reset the pin is low, and the working settings are phase 0, duty 0 and active-high polarity, so the pin stays low through the first period even while enabled.
- R2: With 0 < duty < period and phase + duty <= period, the active level is present for counts phase through phase + duty - 1. The pin shows the level for a count one clock after that count is presented.
- R3: When phase + duty > period, the trailing edge wraps. The active level is present for counts at or above phase and for counts below phase + duty - period.
- R4: A duty of 0 keeps the pin at its inactive level for the whole period.
- R5: A duty equal to or greater than the period keeps the pin at its active level for the whole period.
- R6: Written phase, duty and polarity values apply from the next boundary cycle onward, and that boundary cycle already uses them. A write made in a boundary cycle applies only from the boundary after it.
- R7: Polarity is bit 0 of the written data. 0 means active-high and 1 means active-low. Active-low inverts the pin, and the inactive level is then 1.
- R8: While enable is low, the pin goes to the inactive level of the current polarity one clock later.
- R9: Write select codes are 0 for phase, 1 for duty and 2 for polarity. Code 3, and any select while the write strobe is low, changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel enable; when low the pin idles |
| wrEn | input | 1 | Write strobe for the holding registers |
| wrSel | input | 2 | Write target: 0 phase, 1 duty, 2 polarity, 3 none |
| wrData | input | CNT_W | Write value (polarity uses bit 0) |
| tbCount | input | CNT_W | Shared timebase count |
| tbPeriod | input | CNT_W | Timebase period length in ticks (2 or more) |
| tbBoundary | input | 1 | Timebase strobe, high in the cycle its count is 0 |
| pinOut | output | 1 | PWM pin |

## Verification
The assertions assume a well-behaved timebase. The count stays below `tbPeriod`, the boundary strobe is high exactly when the count is 0, and any phase in use is smaller than the period. The stimulus builds the count from a bench-side up counter that raises the strobe at count 0. It changes the period only at a restart, and it draws random phases below the smallest period it ever selects. Duties, polarity, enable and the timing of writes are random, including writes that land in boundary cycles and duties beyond the period.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam logic [1:0] SEL_PHASE = 2'd0;
  localparam logic [1:0] SEL_DUTY  = 2'd1;
  localparam logic [1:0] SEL_POL   = 2'd2;

  typedef struct packed {
    logic ldPhase;
    logic ldDuty;
    logic ldPol;
    logic commit;
  } spwm_strobe_t;

endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic         tbBoundary,
  output spwm_strobe_t strb
);

  always_comb begin
    strb.ldPhase = wrEn && (wrSel == SEL_PHASE);
    strb.ldDuty  = wrEn && (wrSel == SEL_DUTY);
    strb.ldPol   = wrEn && (wrSel == SEL_POL);
    strb.commit  = tbBoundary;
  end

  // R9: at most one holding register is targeted per write
  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldPhase, strb.ldDuty, strb.ldPol}));

  // R9: no load strobe without a write
  assert_no_stray_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.ldPhase || strb.ldDuty || strb.ldPol));

endmodule

// File: rtl/spwm_window.sv
module spwm_window #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] duty,
  output logic             inWin
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] rawTrail;
  logic [SUM_W-1:0] trail;
  logic [SUM_W-1:0] cntX;
  logic [SUM_W-1:0] phX;
  logic             fullOn;
  logic             zeroOn;

  always_comb begin
    cntX     = {1'b0, count};
    phX      = {1'b0, phase};
    rawTrail = phX + {1'b0, duty};
    trail    = (rawTrail >= {1'b0, period}) ? rawTrail - {1'b0, period} : rawTrail;
    zeroOn   = (duty == '0);
    fullOn   = (duty >= period);
    if (zeroOn)            inWin = 1'b0;
    else if (fullOn)       inWin = 1'b1;
    else if (phX < trail)  inWin = (cntX >= phX) && (cntX < trail);
    else                   inWin = (cntX >= phX) || (cntX < trail);
  end

endmodule

// File: rtl/spwm_datapath.sv
module spwm_datapath
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  spwm_strobe_t     strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] tbCount,
  input  logic [CNT_W-1:0] tbPeriod,
  input  logic             enable,
  output logic             pinOut
);

  logic [CNT_W-1:0] shPhase, shDuty;
  logic             shPol;
  logic [CNT_W-1:0] actPhase, actDuty;
  logic             actPol;
  logic [CNT_W-1:0] effPhase, effDuty;
  logic             effPol;
  logic             inWin;

  // holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPhase <= '0;
      shDuty  <= '0;
      shPol   <= 1'b0;
    end else begin
      if (strb.ldPhase) shPhase <= wrData;
      if (strb.ldDuty)  shDuty  <= wrData;
      if (strb.ldPol)   shPol   <= wrData[0];
    end
  end

  // working registers, loaded at the boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPhase <= '0;
      actDuty  <= '0;
      actPol   <= 1'b0;
    end else if (strb.commit) begin
      actPhase <= shPhase;
      actDuty  <= shDuty;
      actPol   <= shPol;
    end
  end

  // the boundary cycle already compares with the freshly committed values
  always_comb begin
    effPhase = strb.commit ? shPhase : actPhase;
    effDuty  = strb.commit ? shDuty  : actDuty;
    effPol   = strb.commit ? shPol   : actPol;
  end

  spwm_window #(.CNT_W(CNT_W)) u_window (
    .count  (tbCount),
    .period (tbPeriod),
    .phase  (effPhase),
    .duty   (effDuty),
    .inWin  (inWin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinOut <= 1'b0;
    else       pinOut <= enable ? (inWin ^ effPol) : effPol;
  end

  assert_commit_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (actDuty == $past(shDuty)) && (actPhase == $past(shPhase))
                    && (actPol == $past(shPol)));

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(actDuty) && $stable(actPhase) && $stable(actPol));

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> pinOut == $past(effPol));

  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && effDuty == '0) |=> pinOut == $past(effPol));

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && effDuty >= tbPeriod) |=> pinOut != $past(effPol));

  assert_lead_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && effDuty != '0 && tbCount == effPhase && effPhase < tbPeriod)
      |=> pinOut != $past(effPol));

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] tbCount,
  input  logic [CNT_W-1:0] tbPeriod,
  input  logic             tbBoundary,
  output logic             pinOut
);

  spwm_strobe_t strb;

  spwm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .tbBoundary (tbBoundary),
    .strb       (strb)
  );

  spwm_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .tbCount  (tbCount),
    .tbPeriod (tbPeriod),
    .enable   (enable),
    .pinOut   (pinOut)
  );

  // R1: pin is low whenever reset is applied
  always_comb begin
    if (!rstN) assert_reset_low_R1: assert (pinOut == 1'b0);
  end

endmodule

// File: tb/spwm_channel_tb.sv
module spwm_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrSel = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] tbCount = '0;
  logic [W-1:0] tbPeriod = 16'd10;
  logic         tbBoundary = 1'b0;
  logic         pinOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  spwm_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .tbCount(tbCount), .tbPeriod(tbPeriod),
    .tbBoundary(tbBoundary), .pinOut(pinOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  // reference state
  int mShP = 0, mShD = 0, mActP = 0, mActD = 0;
  bit mShPol = 0, mActPol = 0;
  int per = 10;
  int cnt = 9;
  bit en = 0;
  bit expValid = 0;
  bit expPin = 0;
  string expTag = "";

  function automatic bit inWindow(int c, int p, int ph, int d);
    int t;
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    t = (ph + d) % p;
    if (ph < t) return (c >= ph) && (c < t);
    return (c >= ph) || (c < t);
  endfunction

  function automatic string classify(bit e, int p, int ph, int d, bit pol);
    string base;
    if (!e) base = "R8";
    else if (d == 0) base = "R4";
    else if (d >= p) base = "R5";
    else if (ph + d > p) base = "R3";
    else base = "R2";
    return pol ? {base, "/R7"} : base;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: pinOut=%0b expected %0b at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit doWr, int sel, int data, string tag);
    int eP, eD;
    bit ePol, bnd;
    @(negedge clk);
    if (expValid) check(pinOut, expPin, expTag);
    cnt = (cnt + 1 >= per) ? 0 : cnt + 1;
    bnd = (cnt == 0);
    tbPeriod = per[W-1:0];
    tbCount = cnt[W-1:0];
    tbBoundary = bnd;
    enable = en;
    wrEn = doWr;
    wrSel = sel[1:0];
    wrData = data[W-1:0];
    eP = bnd ? mShP : mActP;
    eD = bnd ? mShD : mActD;
    ePol = bnd ? mShPol : mActPol;
    expPin = en ? (inWindow(cnt, per, eP, eD) ^ ePol) : ePol;
    expTag = (tag == "") ? classify(en, per, eP, eD, ePol) : tag;
    expValid = 1;
    if (bnd) begin
      mActP = mShP; mActD = mShD; mActPol = mShPol;
    end
    if (doWr) begin
      case (sel)
        0: mShP = data;
        1: mShD = data;
        2: mShPol = data[0];
        default: ;
      endcase
    end
  endtask

  task automatic setPeriod(int p);
    per = p;
    cnt = p - 1;
  endtask

  task automatic runSteps(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  // write landing exactly in the next boundary cycle
  task automatic writeAtBoundary(int sel, int data, string tag);
    while (cnt != per - 1) step(0, 0, 0, tag);
    step(1, sel, data, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: pinOut=%0b expected run end", pinOut);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(pinOut, 1'b0, "R1");
    end
    @(negedge clk);
    rstN = 1'b1;
    en = 1;
    setPeriod(10);
    runSteps(12, "R1");

    // R2: plain window, phase 2 duty 3
    step(1, 0, 2, "R1");
    step(1, 1, 3, "R1");
    runSteps(9, "");
    runSteps(20, "R2");

    // R6: duty written mid-period waits for the boundary
    while (cnt != 4) step(0, 0, 0, "R2");
    step(1, 1, 6, "R6");
    runSteps(25, "R6");
    // R6: write in the boundary cycle itself is deferred one more period
    writeAtBoundary(1, 1, "R6");
    runSteps(2 * per, "R6");

    // R9: select 3 and strobe-less selects leave settings alone
    step(1, 3, 9, "R9");
    step(0, 1, 0, "R9");
    step(0, 2, 1, "R9");
    runSteps(2 * per, "R9");

    // R3: wrapped trailing edge
    step(1, 0, 7, "R3");
    step(1, 1, 6, "R3");
    runSteps(2 * per, "");

    // R7: active-low
    writeAtBoundary(2, 1, "R7");
    runSteps(2 * per, "");

    // R4 / R5 corners
    step(1, 1, 0, "R4");
    runSteps(2 * per, "");
    step(1, 1, per, "R5");
    runSteps(2 * per, "");
    step(1, 1, per + 5, "R5");
    runSteps(2 * per, "");

    // R8: disable
    en = 0;
    runSteps(per, "R8");
    en = 1;

    // random segments; periods 8..30, phases below 8
    for (int seg = 0; seg < 60; seg++) begin
      int p;
      p = 8 + int'($urandom % 23);
      setPeriod(p);
      en = ($urandom % 6) != 0;
      for (int k = 0; k < 4 * p; k++) begin
        if ($urandom % 6 == 0) begin
          int s, d;
          s = int'($urandom % 4);
          case (s)
            0: d = int'($urandom % 8);
            1: d = int'($urandom % (p + 4));
            default: d = int'($urandom % 2);
          endcase
          step(1, s, d, "");
        end else begin
          step(0, 0, 0, "");
        end
      end
    end

    @(negedge clk);
    if (expValid) check(pinOut, expPin, expTag);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule